// File: doc/BRIEF.md
# Multi-Channel Gated Frequency Counter

This block counts rising edges on a bank of asynchronous digital inputs, all channels at once, over a measurement window set by a gate generator that runs on the reference clock. Each channel keeps a wide edge counter. In reciprocal mode each channel also measures the reference-clock time between the first and the last edge it saw inside the window, so a host can resolve slow signals finely by dividing edge intervals by elapsed ticks. That divide happens outside the block. Only raw counts and a one-cycle done pulse per window are produced here.

A window is opened with a start pulse. The window length is chosen from three lengths, given in reference-clock cycles as parameters, or it is unbounded, in which case it stays open until a stop pulse. While a window is open, a snapshot pulse copies the live counts to the outputs without clearing them. Counting can be qualified by a pattern on the lowest eight inputs: each of those bits has a care flag and an expected value, and edges count only while every cared bit matches.

Top module: `mc_freq_counter`

## Requirements
- R1: After reset, `done` and `busy` are 0 and every count on `evt_cnt` and `tick_cnt` is 0.
- R2: A `start` pulse while idle opens a window: `busy` is high for exactly GATE_A, GATE_B or GATE_C cycles for `gate_sel` 0, 1 or 2. `done` then rises one cycle after `busy` falls and is high for exactly one cycle.
- R3: In direct mode each channel's field in `evt_cnt` (CW bits, channel c at bits c*CW upward) reports the number of low-to-high transitions on that input inside the window. Channels are counted independently. Each level must be held at least two cycles.
- R4: With `recip_en` set, each channel's field in `tick_cnt` (TW bits, channel c at bits c*TW upward) reports the reference cycles between its first and last counted edge, and 0 when fewer than two edges were seen. With `recip_en` clear, `tick_cnt` reports 0.
- R5: With `gate_sel` = 3 the window has no time limit. It closes on the cycle after `stop` is sampled, and `done` follows as in R2.
- R6: A `snap` pulse while `busy` copies the live counts to the outputs on the next cycle. It does not clear the counts, does not pulse `done`, and counting goes on.
- R7: With `pat_en` set, an edge counts only while, for every bit i of the lowest eight inputs with `pat_care[i]` = 1, the synchronised input i equals `pat_val[i]`. Bits with care 0 place no condition.
- R8: A `start` while `busy` is ignored and does not clear the counts. The outputs keep their last values until the next `done` or snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Open a window (idle only) |
| stop | input | 1 | Close the open window |
| snap | input | 1 | Copy live counts to outputs |
| gate_sel | input | 2 | Window length: 0/1/2 fixed, 3 unbounded |
| recip_en | input | 1 | Reciprocal tick measurement on |
| pat_en | input | 1 | Pattern qualification on |
| pat_care | input | 8 | Care flag per low input |
| pat_val | input | 8 | Expected level per low input |
| sig_in | input | NCH | Asynchronous channel inputs |
| busy | output | 1 | Window open |
| done | output | 1 | One-cycle pulse: results ready |
| evt_cnt | output | NCH*CW | Edge counts, channel 0 lowest |
| tick_cnt | output | NCH*TW | Edge-interval ticks, channel 0 lowest |

## Verification
The checks assume that `recip_en` is held steady from a window's start until its done pulse. They also assume that each input level lasts at least two reference cycles, so the synchroniser sees every transition. The directed stimulus changes mode inputs only while the block is idle and after done has been seen. It drives each input transition on the falling clock edge, with high and low phases of two or more cycles, and keeps all edges well inside the window, away from its opening and closing cycles.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    WIN_A    = 2'd0,
    WIN_B    = 2'd1,
    WIN_C    = 2'd2,
    WIN_OPEN = 2'd3
  } win_sel_e;
endpackage

// File: rtl/fc_sync_edge.sv
module fc_sync_edge #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta, stab, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      stab <= '0;
      prev <= '0;
    end else begin
      meta <= din;
      stab <= meta;
      prev <= stab;
    end
  end

  assign lvl  = stab;
  assign rise = stab & ~prev;
endmodule

// File: rtl/fc_gate_gen.sv
module fc_gate_gen
  import fc_pkg::*;
#(
  parameter int unsigned GATE_A = 10_000_000,
  parameter int unsigned GATE_B = 100_000_000,
  parameter int unsigned GATE_C = 1_000_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stop,
  input  logic [1:0] sel,
  output logic       open_o,
  output logic       begin_o,
  output logic       close_o
);
  localparam int unsigned GW = $clog2(GATE_C + 1);

  logic [GW-1:0] remain;
  logic          unbounded;
  logic [GW-1:0] load_len;

  always_comb begin
    unique case (win_sel_e'(sel))
      WIN_A:   load_len = GW'(GATE_A - 1);
      WIN_B:   load_len = GW'(GATE_B - 1);
      WIN_C:   load_len = GW'(GATE_C - 1);
      default: load_len = '0;
    endcase
  end

  assign begin_o = start & ~open_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_o    <= 1'b0;
      close_o   <= 1'b0;
      remain    <= '0;
      unbounded <= 1'b0;
    end else begin
      close_o <= 1'b0;
      if (!open_o) begin
        if (start) begin
          open_o    <= 1'b1;
          remain    <= load_len;
          unbounded <= (win_sel_e'(sel) == WIN_OPEN);
        end
      end else if (stop || (!unbounded && remain == '0)) begin
        open_o  <= 1'b0;
        close_o <= 1'b1;
      end else if (!unbounded) begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_chan.sv
module fc_chan #(
  parameter int unsigned CW = 64,
  parameter int unsigned TW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          gate,
  input  logic          rise,
  input  logic          qual,
  input  logic          recip,
  input  logic          latch,
  output logic [CW-1:0] evt_o,
  output logic [TW-1:0] tick_o
);
  logic [CW-1:0] evt;
  logic [TW-1:0] run, last;
  logic          seen;
  logic          hit;

  assign hit = gate & qual & rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt    <= '0;
      run    <= '0;
      last   <= '0;
      seen   <= 1'b0;
      evt_o  <= '0;
      tick_o <= '0;
    end else begin
      if (clear) begin
        evt  <= '0;
        run  <= '0;
        last <= '0;
        seen <= 1'b0;
      end else begin
        if (hit) evt <= evt + 1'b1;
        // R4: ticks run from the first counted edge, captured at each later one
        if (recip && gate) begin
          if (!seen) begin
            if (hit) begin
              seen <= 1'b1;
              run  <= TW'(1);
            end
          end else begin
            run <= run + 1'b1;
            if (hit) last <= run;
          end
        end
      end
      if (latch) begin
        evt_o  <= evt;
        tick_o <= recip ? last : '0;
      end
    end
  end
endmodule

// File: rtl/mc_freq_counter.sv
module mc_freq_counter #(
  parameter int unsigned NCH    = 18,
  parameter int unsigned CW     = 64,
  parameter int unsigned TW     = 40,
  parameter int unsigned GATE_A = 10_000_000,
  parameter int unsigned GATE_B = 100_000_000,
  parameter int unsigned GATE_C = 1_000_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              snap,
  input  logic [1:0]        gate_sel,
  input  logic              recip_en,
  input  logic              pat_en,
  input  logic [7:0]        pat_care,
  input  logic [7:0]        pat_val,
  input  logic [NCH-1:0]    sig_in,
  output logic              busy,
  output logic              done,
  output logic [NCH*CW-1:0] evt_cnt,
  output logic [NCH*TW-1:0] tick_cnt
);
  localparam int unsigned PW = 8;

  logic [NCH-1:0] lvl, rise;
  logic           gate, begin_w, close_w;
  logic           recip_r;
  logic           match, qual, latch;
  logic [NCH-1:0] care_ext, val_ext;

  fc_sync_edge #(.W(NCH)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (sig_in),
    .lvl (lvl),
    .rise(rise)
  );

  fc_gate_gen #(.GATE_A(GATE_A), .GATE_B(GATE_B), .GATE_C(GATE_C)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .stop   (stop),
    .sel    (gate_sel),
    .open_o (gate),
    .begin_o(begin_w),
    .close_o(close_w)
  );

  // R7: care/value apply to the lowest PW channels only
  generate
    if (NCH > PW) begin : g_ext
      assign care_ext = {{(NCH-PW){1'b0}}, pat_care};
      assign val_ext  = {{(NCH-PW){1'b0}}, pat_val};
    end else begin : g_trunc
      assign care_ext = pat_care[NCH-1:0];
      assign val_ext  = pat_val[NCH-1:0];
    end
  endgenerate

  assign match = &(~care_ext | ~(lvl ^ val_ext));
  assign qual  = ~pat_en | match;
  // R6: snapshot only while the window is open
  assign latch = close_w | (snap & gate);

  always_ff @(posedge clk) begin
    if (rst) begin
      recip_r <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (begin_w) recip_r <= recip_en;
      done <= close_w;
    end
  end

  assign busy = gate;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      fc_chan #(.CW(CW), .TW(TW)) u_ch (
        .clk   (clk),
        .rst   (rst),
        .clear (begin_w),
        .gate  (gate),
        .rise  (rise[c]),
        .qual  (qual),
        .recip (recip_r),
        .latch (latch),
        .evt_o (evt_cnt[c*CW +: CW]),
        .tick_o(tick_cnt[c*TW +: TW])
      );
    end
  endgenerate
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
  parameter int unsigned NCH = 18,
  parameter int unsigned CW  = 64,
  parameter int unsigned TW  = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              stop,
  input logic              snap,
  input logic              recip_en,
  input logic              busy,
  input logic              done,
  input logic [NCH*CW-1:0] evt_cnt,
  input logic [NCH*TW-1:0] tick_cnt
);
  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R5
  stop_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && stop) |=> !busy);

  // R4
  direct_ticks_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !recip_en) |-> (tick_cnt == '0));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(evt_cnt) |-> (done || $past(snap && busy)));
endmodule

bind mc_freq_counter fc_checker #(.NCH(NCH), .CW(CW), .TW(TW)) i_fc_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .stop    (stop),
  .snap    (snap),
  .recip_en(recip_en),
  .busy    (busy),
  .done    (done),
  .evt_cnt (evt_cnt),
  .tick_cnt(tick_cnt)
);

// File: tb/test_mc_freq_counter.sv
module test_mc_freq_counter;
  localparam int unsigned NCH = 18;
  localparam int unsigned CW  = 64;
  localparam int unsigned TW  = 40;
  localparam int unsigned GA  = 30;
  localparam int unsigned GB  = 60;
  localparam int unsigned GC  = 120;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0, stop = 1'b0, snap = 1'b0;
  logic [1:0]        gate_sel = 2'd0;
  logic              recip_en = 1'b0, pat_en = 1'b0;
  logic [7:0]        pat_care = '0, pat_val = '0;
  logic [NCH-1:0]    sig_in = '0;
  logic              busy, done;
  logic [NCH*CW-1:0] evt_cnt;
  logic [NCH*TW-1:0] tick_cnt;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mc_freq_counter #(.NCH(NCH), .CW(CW), .TW(TW),
                    .GATE_A(GA), .GATE_B(GB), .GATE_C(GC)) i_mc_freq_counter (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .snap(snap),
    .gate_sel(gate_sel), .recip_en(recip_en), .pat_en(pat_en),
    .pat_care(pat_care), .pat_val(pat_val), .sig_in(sig_in),
    .busy(busy), .done(done), .evt_cnt(evt_cnt), .tick_cnt(tick_cnt)
  );

  function automatic logic [CW-1:0] evt_of(input int c);
    return evt_cnt[c*CW +: CW];
  endfunction

  function automatic logic [TW-1:0] tick_of(input int c);
    return tick_cnt[c*TW +: TW];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [1:0] sel);
    gate_sel = sel;
    start = 1'b1;
    cyc(1);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && done !== 1'b1; i++) cyc(1);
  endtask

  // rising edges on every channel of mask, high hi cycles, period per cycles
  task automatic pulses(input logic [NCH-1:0] mask, input int n, input int hi, input int per);
    for (int k = 0; k < n; k++) begin
      sig_in = sig_in | mask;
      cyc(hi);
      sig_in = sig_in & ~mask;
      cyc(per - hi);
    end
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    chk("R1 evt", evt_cnt == '0, 1);
    chk("R1 tick", tick_cnt == '0, 1);
  endtask

  task automatic t_window_len();
    int len [3];
    len[0] = GA; len[1] = GB; len[2] = GC;
    for (int s = 0; s < 3; s++) begin
      int n = 0;
      kick(2'(s));
      while (busy === 1'b1 && n < 1000) begin n++; cyc(1); end
      chk($sformatf("R2 busy length sel%0d", s), n, len[s]);
      chk("R2 done low as busy falls", done, 0);
      cyc(1);
      chk("R2 done pulse", done, 1);
      cyc(1);
      chk("R2 done single", done, 0);
      chk("R3 no edges no counts", evt_cnt == '0, 1);
    end
  endtask

  task automatic t_direct();
    recip_en = 1'b0;
    kick(2'd1);
    cyc(3);
    for (int i = 0; i < 4; i++) begin
      logic [NCH-1:0] m = '0;
      for (int c = 0; c < NCH; c++) if ((c % 5) > i) m[c] = 1'b1;
      pulses(m, 1, 2, 4);
    end
    wait_done();
    cyc(1);
    for (int c = 0; c < NCH; c++) begin
      chk($sformatf("R3 ch%0d edges", c), evt_of(c), c % 5);
      chk($sformatf("R4 ch%0d direct ticks", c), tick_of(c), 0);
    end
  endtask

  task automatic t_recip();
    recip_en = 1'b1;
    kick(2'd2);
    cyc(3);
    fork
      pulses(18'h00001, 4, 3, 6);
      pulses(18'h00002, 1, 2, 4);
      pulses(18'h00004, 3, 4, 10);
    join
    wait_done();
    cyc(1);
    chk("R4 ch0 edges", evt_of(0), 4);
    chk("R4 ch0 ticks", tick_of(0), 18);
    chk("R4 ch1 single edge ticks", tick_of(1), 0);
    chk("R4 ch2 ticks", tick_of(2), 20);
    chk("R4 quiet ch5 ticks", tick_of(5), 0);
    recip_en = 1'b0;
    cyc(2);
  endtask

  task automatic t_unbounded();
    kick(2'd3);
    cyc(GC + 20);
    chk("R5 still open past longest", busy, 1);
    pulses(18'h00008, 2, 2, 4);
    cyc(4);
    snap = 1'b1;
    cyc(1);
    snap = 1'b0;
    chk("R6 snapshot count", evt_of(3), 2);
    chk("R6 no done on snapshot", done, 0);
    chk("R6 still open", busy, 1);
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    pulses(18'h00008, 1, 2, 4);
    cyc(4);
    chk("R8 outputs held", evt_of(3), 2);
    stop = 1'b1;
    cyc(1);
    stop = 1'b0;
    chk("R5 closed after stop", busy, 0);
    chk("R8 held until done", evt_of(3), 2);
    cyc(1);
    chk("R5 done after stop", done, 1);
    chk("R6 R8 count kept", evt_of(3), 3);
    cyc(1);
  endtask

  task automatic t_pattern();
    pat_en = 1'b1;
    pat_care = 8'h03;
    pat_val = 8'h01;
    sig_in[0] = 1'b1;
    cyc(4);
    kick(2'd2);
    cyc(3);
    pulses(18'h00220, 2, 2, 4);
    sig_in[1] = 1'b1;
    cyc(4);
    pulses(18'h00220, 3, 2, 4);
    wait_done();
    cyc(1);
    chk("R7 ch5 counted while matched", evt_of(5), 2);
    chk("R7 ch9 counted while matched", evt_of(9), 2);
    chk("R7 ch1 edge breaks match", evt_of(1), 0);
    pat_care = 8'h00;
    kick(2'd0);
    cyc(3);
    pulses(18'h00020, 3, 2, 4);
    wait_done();
    cyc(1);
    chk("R7 no care bits counts all", evt_of(5), 3);
    sig_in = '0;
    pat_en = 1'b0;
    cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_window_len();
    t_direct();
    t_recip();
    t_unbounded();
    t_pattern();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule